// File: doc/BRIEF.md
# Microsecond Event Timer

This block is one programmable down-counting timer that advances on an external one-microsecond tick enable. Software arms it with a single word that holds three things: an enable bit, a mode bit that picks one-shot or auto-reload, and a count. When the count runs out, the timer raises a pending flag. The flag drives an active-high level interrupt line, and that line stays high until software writes a one to the clear bit in the status word.

A count of L gives an expiry on the (L+1)th tick, so an interval of N ticks is programmed as N − 1. A requested interval of one tick, or of zero, is programmed as 0. In one-shot mode the timer disarms itself at expiry. In auto-reload mode it reloads the programmed count and keeps running, which gives a period of L+1 ticks. The status word returns the pending flag together with the live count. Writes are single-cycle strobes. Reads are combinational from a separate read address.

Top module: `usec_timer`

## Requirements
- R1: After reset, irq is low, and both the control word (offset 0x0) and the status word (offset 0x4) read as zero.
- R2: The control word at byte offset 0x0 holds the enable in bit 31, auto-reload mode in bit 30 and the count in bits [CNT_W-1:0]. Reading it returns the live enable, the mode and the programmed count, and all other bits read as zero.
- R3: While enabled, the count drops by one on each cycle with tick_en high. A loaded count L expires on the (L+1)th tick. In cycles without tick_en the count holds.
- R4: At a one-shot expiry (bit 30 = 0), the pending flag sets, the enable bit clears and the count stays at 0. No further expiry follows until the next write.
- R5: At an auto-reload expiry (bit 30 = 1), the pending flag sets, the count reloads the programmed value and the enable stays set. Expiries then repeat every L+1 ticks.
- R6: The status word at byte offset 0x4 returns the pending flag in bit 30 and the current count in bits [CNT_W-1:0]. All other bits read as zero.
- R7: A write to offset 0x4 with bit 30 = 1 clears the pending flag. A write to that offset with bit 30 = 0 leaves the flag unchanged.
- R8: When an expiry and a clear fall in the same cycle, the pending flag stays set.
- R9: A write to offset 0x0 restarts the count from the new value. It takes precedence over a tick in the same cycle and leaves a pending flag untouched.
- R10: Writing 0 to offset 0x0 disarms the timer. While the enable is clear, ticks change neither the count nor the flag.
- R11: irq is the pending flag. It rises in the cycle after the edge on which the expiring tick is sampled and stays high until cleared.
- R12: Writes to any offset other than 0x0 and 0x4 have no effect, and reads from such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-microsecond tick enable, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the timer with CNT_W = 10 and the default ADDR_W = 4. With that width, the full-scale count 0x3FF can run all the way to expiry, and the check that the expiry lands on exactly the 1024th tick fits easily in the run. The control and status bit positions (31, 30) do not depend on CNT_W, so the narrower field exercises the same decode and read layout as the default 29-bit build. The large example periods that need the full 29-bit field lie outside this build. They use the same decrement and reload path that the short periods exercise.

// File: rtl/ut_pkg.sv
package ut_pkg;
  localparam int UT_DATA_W   = 32;
  localparam int UT_EN_BIT   = 31;
  localparam int UT_MODE_BIT = 30;
  localparam int UT_CLR_BIT  = 30;
  localparam int UT_OFS_CTRL = 0;
  localparam int UT_OFS_STAT = 4;

  typedef struct packed {
    logic en;
    logic periodic;
  } ut_mode_t;
endpackage

// File: rtl/ut_rst_sync.sv
module ut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/ut_regif.sv
module ut_regif
  import ut_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 4
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [UT_DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  ut_mode_t             mode_q,
  input  logic [CNT_W-1:0]     reload_q,
  input  logic [CNT_W-1:0]     count_q,
  input  logic                 pend_q,
  output logic                 wr_ctrl,
  output ut_mode_t             wr_mode,
  output logic [CNT_W-1:0]     wr_count,
  output logic                 clr_req,
  output logic [UT_DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] CtrlOfs = ADDR_W'(UT_OFS_CTRL);
  localparam logic [ADDR_W-1:0] StatOfs = ADDR_W'(UT_OFS_STAT);

  // write decode
  always_comb begin
    wr_ctrl          = wr_en && (wr_addr == CtrlOfs);
    wr_mode.en       = wr_data[UT_EN_BIT];
    wr_mode.periodic = wr_data[UT_MODE_BIT];
    wr_count         = wr_data[CNT_W-1:0];
    clr_req          = wr_en && (wr_addr == StatOfs) && wr_data[UT_CLR_BIT];
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == CtrlOfs) begin
      rd_data[UT_EN_BIT]   = mode_q.en;
      rd_data[UT_MODE_BIT] = mode_q.periodic;
      rd_data[CNT_W-1:0]   = reload_q;
    end else if (rd_addr == StatOfs) begin
      rd_data[UT_CLR_BIT]  = pend_q;
      rd_data[CNT_W-1:0]   = count_q;
    end
  end
endmodule

// File: rtl/ut_counter.sv
module ut_counter
  import ut_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_ctrl,
  input  ut_mode_t         wr_mode,
  input  logic [CNT_W-1:0] wr_count,
  output ut_mode_t         mode_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  ut_mode_t         mode_d;
  logic [CNT_W-1:0] reload_d;
  logic [CNT_W-1:0] count_d;
  logic             at_zero;
  logic             step;

  always_comb begin
    at_zero  = (count_q == '0);
    step     = mode_q.en && tick_en && !wr_ctrl;
    expire   = step && at_zero;
    mode_d   = mode_q;
    reload_d = reload_q;
    count_d  = count_q;
    if (wr_ctrl) begin
      mode_d   = wr_mode;
      reload_d = wr_count;
      count_d  = wr_count;
    end else if (step) begin
      if (at_zero) begin
        if (mode_q.periodic) count_d   = reload_q;
        else                 mode_d.en = 1'b0;
      end else begin
        count_d = count_q - CntOne;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      count_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      reload_q <= reload_d;
      count_q  <= count_d;
    end
  end
endmodule

// File: rtl/ut_pending.sv
module ut_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic pend_q
);
  logic pend_d;

  // a new expiry outranks a clear in the same cycle
  always_comb pend_d = set_req || (pend_q && !clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import ut_pkg::*;
#(
  parameter int CNT_W  = 29,  // count field width, at most 30
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [UT_DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [UT_DATA_W-1:0] rd_data,
  output logic                 irq
);
  logic             rst_sync_n;
  logic             wr_ctrl;
  ut_mode_t         wr_mode;
  logic [CNT_W-1:0] wr_count;
  logic             clr_req;
  ut_mode_t         mode_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             expire;
  logic             pend_q;

  ut_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ut_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .mode_q   (mode_q),
    .reload_q (reload_q),
    .count_q  (count_q),
    .pend_q   (pend_q),
    .wr_ctrl  (wr_ctrl),
    .wr_mode  (wr_mode),
    .wr_count (wr_count),
    .clr_req  (clr_req),
    .rd_data  (rd_data)
  );

  ut_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .wr_ctrl  (wr_ctrl),
    .wr_mode  (wr_mode),
    .wr_count (wr_count),
    .mode_q   (mode_q),
    .reload_q (reload_q),
    .count_q  (count_q),
    .expire   (expire)
  );

  ut_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_req (expire),
    .clr_req (clr_req),
    .pend_q  (pend_q)
  );

  assign irq = pend_q;
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tick_en,
  input logic             wr_ctrl,
  input logic             clr_req,
  input logic             en,
  input logic             periodic,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_q,
  input logic             expire,
  input logic             irq
);
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && tick_en && !wr_ctrl && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));

  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick_en && !wr_ctrl) |=> $stable(count_q));

  a_r4_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (expire && !periodic) |=> (!en && count_q == '0));

  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (expire && periodic) |=> (en && count_q == $past(reload_q)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_req && !expire) |=> !irq);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> irq);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en && !wr_ctrl) |=> (!en && $stable(count_q) && !expire));

  a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !clr_req) |=> irq);
endmodule

bind usec_timer usec_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_en    (tick_en),
  .wr_ctrl    (wr_ctrl),
  .clr_req    (clr_req),
  .en         (mode_q.en),
  .periodic   (mode_q.periodic),
  .reload_q   (reload_q),
  .count_q    (count_q),
  .expire     (expire),
  .irq        (irq)
);

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
  localparam int CNT_W  = 10;
  localparam int ADDR_W = 4;
  localparam logic [31:0] MAXC = (32'd1 << CNT_W) - 32'd1;
  localparam logic [31:0] PEND = 32'h4000_0000;

  logic              clk;
  logic              rst_n;
  logic              tick_en;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_data;
  logic              irq;

  int n_run;
  int n_fail;
  int cycles;
  bit done;

  usec_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_usec_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h0, v); check("R1 ctrl after reset", v, 32'h0);
    rd(4'h4, v); check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_oneshot_min;
    logic [31:0] v;
    wr(4'h0, 32'h8000_0000);
    rd(4'h0, v); check("R2 ctrl readback", v, 32'h8000_0000);
    check("R11 irq before tick", {31'h0, irq}, 32'h0);
    tick(1);
    check("R3 L=0 expires on first tick", {31'h0, irq}, 32'h1);
    rd(4'h0, v); check("R4 enable cleared", v, 32'h0000_0000);
    rd(4'h4, v); check("R6 status pending", v, PEND);
    wr(4'h4, PEND);
    check("R7 clear drops irq", {31'h0, irq}, 32'h0);
    tick(3);
    check("R4 no refire", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_oneshot_five;
    logic [31:0] v;
    wr(4'h0, 32'h8000_0004);
    tick(2);
    rd(4'h4, v); check("R6 live count", v, 32'h2);
    repeat (6) @(negedge clk);
    rd(4'h4, v); check("R3 holds without tick", v, 32'h2);
    tick(2);
    check("R3 no expiry after 4 ticks", {31'h0, irq}, 32'h0);
    tick(1);
    check("R3 expiry on 5th tick", {31'h0, irq}, 32'h1);
    repeat (4) @(negedge clk);
    check("R11 level held", {31'h0, irq}, 32'h1);
    wr(4'h4, 32'hBFFF_FFFF);
    check("R7 clear bit zero ignored", {31'h0, irq}, 32'h1);
    wr(4'h0, 32'h8000_0003);
    check("R9 ctrl write keeps pending", {31'h0, irq}, 32'h1);
    rd(4'h4, v); check("R9 restart count", v, PEND | 32'h3);
    wr(4'h0, 32'h0);
    wr(4'h4, PEND);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(4'h0, 32'hC000_0003);
    tick(3);
    check("R5 no expiry after 3", {31'h0, irq}, 32'h0);
    tick(1);
    check("R5 first period", {31'h0, irq}, 32'h1);
    rd(4'h0, v); check("R5 stays enabled", v, 32'hC000_0003);
    rd(4'h4, v); check("R5 reloaded", v, PEND | 32'h3);
    wr(4'h4, PEND);
    tick(3);
    check("R5 second period early", {31'h0, irq}, 32'h0);
    tick(1);
    check("R5 second period", {31'h0, irq}, 32'h1);
    wr(4'h4, PEND);
    wr(4'h0, 32'h0);
    tick(10);
    check("R10 disabled no irq", {31'h0, irq}, 32'h0);
    rd(4'h4, v); check("R10 disabled count", v, 32'h0);
  endtask

  task automatic t_no_enable;
    logic [31:0] v;
    wr(4'h0, 32'h4000_0002);
    tick(5);
    rd(4'h4, v); check("R10 mode without enable holds", v, 32'h2);
    check("R10 no irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(4'h0, 32'h8000_0009);
    tick(4);
    rd(4'h4, v); check("R3 count after 4", v, 32'h5);
    wr(4'h0, 32'h8000_0002);
    rd(4'h4, v); check("R9 restart value", v, 32'h2);
    tick(2);
    check("R9 no early expiry", {31'h0, irq}, 32'h0);
    tick(1);
    check("R9 expiry after restart", {31'h0, irq}, 32'h1);
    wr(4'h4, PEND);
    // write and tick together: write wins
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'h0; wr_data = 32'h8000_0005; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    rd(4'h4, v); check("R9 write beats tick", v, 32'h5);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_set_wins;
    wr(4'h0, 32'h8000_0000);
    tick(1);
    wr(4'h0, 32'h8000_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'h4; wr_data = PEND; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    check("R8 expiry beats clear", {31'h0, irq}, 32'h1);
    wr(4'h4, PEND);
    check("R7 clear after", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R12 ctrl untouched", v, 32'h0);
    rd(4'h8, v); check("R12 unmapped read", v, 32'h0);
    tick(3);
    check("R12 no irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_max;
    logic [31:0] v;
    wr(4'h0, 32'h8000_0000 | MAXC);
    rd(4'h0, v); check("R2 full-scale readback", v, 32'h8000_0000 | MAXC);
    tick(int'(MAXC));
    rd(4'h4, v); check("R3 full-scale at zero", v, 32'h0);
    tick(1);
    check("R3 full-scale expiry", {31'h0, irq}, 32'h1);
    wr(4'h4, PEND);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_oneshot_min();
    t_oneshot_five();
    t_periodic();
    t_no_enable();
    t_restart();
    t_set_wins();
    t_unmapped();
    t_max();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule